// File: doc/BRIEF.md
# Bus-Activity Watchdog and Reset Generator

This block supervises a host processor by watching the two lines of its serial bus. The host proves it is alive by sending a start condition followed later by a stop condition. Each such pair restarts a watchdog counter. If the selected interval elapses without a restart, the block raises its reset output. The interval is chosen with a two-bit select and counted in ticks of a 1 kHz timebase. One select code turns the watchdog off.

The same output also covers supply events. After power-up, and whenever the supply-good comparator flag drops, reset is held active. It is released only once the flag has stayed high for a fixed hold time of 200 ticks. A watchdog expiry restarts this same hold, so every reset pulse the block makes lasts the full hold time. The polarity of the output is chosen by a parameter.

Top module: `busdog_top`

## Requirements
- R1: While `rstN` is low, and right after it is released, the reset output is asserted. With the default `ACTIVE_LOW = 1`, asserted means `rstOut = 0`.
- R2: With `supplyOk` held high, reset stays asserted through 199 ticks and is released on the 200th tick.
- R3: A low `supplyOk` asserts reset from the next clock edge. After `supplyOk` returns high, reset is released on the 200th tick, and not before.
- R4: The period select encodes 00 as 1400 ticks, 01 as 600 ticks and 10 as 200 ticks. Reset is asserted on the Nth tick after the last restart and is still released after N-1 ticks.
- R5: Select 11 disables the watchdog. No number of ticks then asserts reset.
- R6: A restart is a start (SDA falling while SCL is high) followed by a stop (SDA rising while SCL is high). It sets the count back to zero.
- R7: A start with no following stop, or a stop with no preceding start, does not restart the watchdog.
- R8: While reset is asserted, the watchdog count is held at zero and no ticks accumulate. After release, a full period is needed before expiry.
- R9: Changing the period select restarts the count from zero under the new period.
- R10: A watchdog expiry asserts reset for exactly the 200-tick hold time. Reset is then released, provided `supplyOk` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| sclIn | input | 1 | Serial bus clock line, asynchronous |
| sdaIn | input | 1 | Serial bus data line, asynchronous |
| periodSel | input | 2 | Watchdog period select (00 slow, 01 mid, 10 fast, 11 off) |
| supplyOk | input | 1 | Supply-good comparator flag, high when the supply is above its trip level |
| tickIn | input | 1 | One-cycle pulse at 1 kHz, the timebase |
| rstOut | output | 1 | Reset output, polarity set by `ACTIVE_LOW` |

## Verification
Supply and watchdog effects pass through one register, so they appear on `rstOut` in the cycle after the edge that samples the deciding tick or the low `supplyOk`. The bench drives each tick for exactly one rising edge and reads `rstOut` on the following falling edge. Bus events pass through a two-stage synchronizer and an edge register, so they take three edges to act. The bench therefore holds each line level for four cycles and never sends a tick while a bus sequence is in progress. Every boundary is checked on both sides, at N-1 ticks and at N ticks.

// File: rtl/busdog_pkg.sv
package busdog_pkg;

  // strobes passed from control to the watchdog datapath
  typedef struct packed {
    logic clearCnt;  // hold the counter at zero this cycle
    logic kick;      // bus start-then-stop restart seen
    logic tick;      // timebase pulse
  } wdStrobe_t;

  localparam logic [1:0] SEL_OFF = 2'b11;

endpackage

// File: rtl/busdog_ctrl.sv
module busdog_ctrl
  import busdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] periodSel,
  input  logic       supplyOk,
  input  logic       tickIn,
  input  logic       wdExpire,
  output wdStrobe_t  strobe,
  output logic       rstActive
);

  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_DONE = HW'(HOLD_TICKS);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sdaPrev;
  logic busStart, busStop, armed;
  logic [HW-1:0] holdCnt;
  logic [1:0] selPrev;
  logic selChanged;

  // both bus lines pass through synchronizers of equal depth, so their
  // relative ordering is kept
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= sclIn;
          sdaSh <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSh <= '1;
          sdaSh <= '1;
        end else begin
          sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
          sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclSh[SYNC_STAGES-1];
  assign sdaS = sdaSh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaPrev <= 1'b1;
    else       sdaPrev <= sdaS;
  end

  assign busStart = sclS &  sdaPrev & ~sdaS;
  assign busStop  = sclS & ~sdaPrev &  sdaS;

  // a start arms the restart; the next stop completes it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (rstActive) armed <= 1'b0;
    else if (busStart)  armed <= 1'b1;
    else if (busStop)   armed <= 1'b0;
  end

  // hold counter: reaches HOLD_DONE only after an unbroken run of good supply
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      holdCnt <= '0;
    else if (!supplyOk || wdExpire) holdCnt <= '0;
    else if (tickIn && rstActive)   holdCnt <= holdCnt + HW'(1);
  end

  assign rstActive = (holdCnt != HOLD_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selPrev <= SEL_OFF;
    else       selPrev <= periodSel;
  end

  assign selChanged = (selPrev != periodSel);

  always_comb begin
    strobe.clearCnt = rstActive | selChanged;
    strobe.kick     = busStop & armed;
    strobe.tick     = tickIn;
  end

endmodule

// File: rtl/busdog_dpath.sv
module busdog_dpath
  import busdog_pkg::*;
#(
  parameter int TICKS_SLOW = 1400,
  parameter int TICKS_MID  = 600,
  parameter int TICKS_FAST = 200,
  parameter int CW         = $clog2(TICKS_SLOW + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  wdStrobe_t     strobe,
  input  logic [1:0]    periodSel,
  output logic          wdExpire,
  output logic [CW-1:0] wdCount
);

  logic [CW-1:0] lastCount;
  logic enabled;

  always_comb begin
    unique case (periodSel)
      2'b00:   lastCount = CW'(TICKS_SLOW - 1);
      2'b01:   lastCount = CW'(TICKS_MID - 1);
      default: lastCount = CW'(TICKS_FAST - 1);
    endcase
  end

  assign enabled  = (periodSel != SEL_OFF);
  assign wdExpire = strobe.tick & enabled & ~strobe.clearCnt & ~strobe.kick
                  & (wdCount == lastCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     wdCount <= '0;
    else if (strobe.clearCnt || strobe.kick || !enabled) wdCount <= '0;
    else if (wdExpire)                             wdCount <= '0;
    else if (strobe.tick)                          wdCount <= wdCount + CW'(1);
  end

endmodule

// File: rtl/busdog_top.sv
module busdog_top
  import busdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 200,
  parameter int TICKS_SLOW  = 1400,
  parameter int TICKS_MID   = 600,
  parameter int TICKS_FAST  = 200,
  parameter bit ACTIVE_LOW  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] periodSel,
  input  logic       supplyOk,
  input  logic       tickIn,
  output logic       rstOut
);

  localparam int CNT_W = $clog2(TICKS_SLOW + 1);

  wdStrobe_t strobe;
  logic rstActive;
  logic wdExpire;
  logic [CNT_W-1:0] wdCount;

  busdog_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_TICKS (HOLD_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .periodSel(periodSel),
    .supplyOk (supplyOk),
    .tickIn   (tickIn),
    .wdExpire (wdExpire),
    .strobe   (strobe),
    .rstActive(rstActive)
  );

  busdog_dpath #(
    .TICKS_SLOW(TICKS_SLOW),
    .TICKS_MID (TICKS_MID),
    .TICKS_FAST(TICKS_FAST),
    .CW        (CNT_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .periodSel(periodSel),
    .wdExpire (wdExpire),
    .wdCount  (wdCount)
  );

  generate
    if (ACTIVE_LOW) begin : g_low
      assign rstOut = ~rstActive;
    end else begin : g_high
      assign rstOut = rstActive;
    end
  endgenerate

endmodule

// File: rtl/busdog_chk.sv
module busdog_chk #(
  parameter int CW         = 11,
  parameter int TICKS_SLOW = 1400
) (
  input logic          clk,
  input logic          rstN,
  input logic          supplyOk,
  input logic [1:0]    periodSel,
  input logic          tickIn,
  input logic          rstActive,
  input logic          wdExpire,
  input logic [CW-1:0] wdCount
);

  // R3
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> rstActive);

  // R8
  held_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstActive |=> (wdCount == '0));

  // R10
  expire_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdExpire |=> rstActive);

  // R5
  disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodSel == 2'b11) |-> !wdExpire);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdCount < CW'(TICKS_SLOW));

  // R2
  release_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstActive) |-> $past(tickIn && supplyOk));

endmodule

bind busdog_top busdog_chk #(
  .CW        (CNT_W),
  .TICKS_SLOW(TICKS_SLOW)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .supplyOk (supplyOk),
  .periodSel(periodSel),
  .tickIn   (tickIn),
  .rstActive(rstActive),
  .wdExpire (wdExpire),
  .wdCount  (wdCount)
);

// File: tb/test_busdog_top.sv
module test_busdog_top;

  logic clk = 1'b0;
  logic rstN, scl, sda, supplyOk, tick;
  logic [1:0] sel;
  logic rstOut;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  busdog_top i_busdog_top (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (scl),
    .sdaIn    (sda),
    .periodSel(sel),
    .supplyOk (supplyOk),
    .tickIn   (tick),
    .rstOut   (rstOut)
  );

  // vector table: select, ticks after a restart, reset expected
  localparam int NV = 7;
  localparam logic [1:0] VSEL [NV] = '{2'b10, 2'b10, 2'b01, 2'b01, 2'b00, 2'b00, 2'b11};
  localparam int         VN   [NV] = '{199, 200, 599, 600, 1399, 1400, 1500};
  localparam bit         VEXP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  // asserted means rstOut low (ACTIVE_LOW default)
  function automatic bit asserted();
    return (rstOut == 1'b0);
  endfunction

  task automatic check(input bit expAsserted, input string req);
    total++;
    if (asserted() !== expAsserted) begin
      bad++;
      $display("FAIL %s: reset asserted=%0b expected=%0b at %0t", req, asserted(), expAsserted, $time);
    end
  endtask

  task automatic tickN(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic busPins(input logic s, input logic d);
    @(negedge clk);
    scl = s;
    sda = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic kick();
    busPins(1, 1); busPins(1, 0); busPins(0, 0); busPins(1, 0); busPins(1, 1);
  endtask

  task automatic startOnly();
    busPins(1, 1); busPins(1, 0); busPins(0, 0); busPins(0, 1); busPins(1, 1);
  endtask

  task automatic stopOnly();
    busPins(1, 1); busPins(0, 1); busPins(0, 0); busPins(1, 0); busPins(1, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; scl = 1'b1; sda = 1'b1; supplyOk = 1'b1; tick = 1'b0; sel = 2'b11;
    repeat (5) @(negedge clk);
    check(1'b1, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(1'b1, "R1 after reset");

    tickN(199); check(1'b1, "R2 hold 199");
    tickN(1);   check(1'b0, "R2 hold 200");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) sel = VSEL[i];
      kick();
      tickN(VN[i]);
      check(VEXP[i], (VSEL[i] == 2'b11) ? "R5 disabled" : "R4 period");
      if (VEXP[i]) begin
        tickN(200);
        check(1'b0, "R10 recover");
      end
    end

    // R10 exact pulse length
    @(negedge clk) sel = 2'b10;
    kick();
    tickN(200); check(1'b1, "R10 expire");
    tickN(199); check(1'b1, "R10 pulse 199");
    tickN(1);   check(1'b0, "R10 pulse 200");

    // R6 restart mid period
    kick(); tickN(150); kick();
    tickN(199); check(1'b0, "R6 after kick 199");
    tickN(1);   check(1'b1, "R6 after kick 200");
    tickN(200);

    // R7 start without stop
    kick(); tickN(150); startOnly();
    tickN(49); check(1'b0, "R7 start only 199");
    tickN(1);  check(1'b1, "R7 start only 200");
    tickN(200);

    // R7 stop without start
    kick(); tickN(150); stopOnly();
    tickN(50); check(1'b1, "R7 stop only 200");
    tickN(200);

    // R9 select change reloads
    @(negedge clk) sel = 2'b00;
    kick(); tickN(150);
    @(negedge clk) sel = 2'b10;
    tickN(199); check(1'b0, "R9 reload 199");
    tickN(1);   check(1'b1, "R9 reload 200");
    tickN(200);

    // R3 and R8 supply drop
    kick(); tickN(100);
    @(negedge clk) supplyOk = 1'b0;
    @(negedge clk);
    check(1'b1, "R3 drop next edge");
    tickN(500); check(1'b1, "R8 held while low");
    @(negedge clk) supplyOk = 1'b1;
    tickN(199); check(1'b1, "R3 regain 199");
    tickN(1);   check(1'b0, "R3 regain 200");
    tickN(199); check(1'b0, "R8 fresh count 199");
    tickN(1);   check(1'b1, "R8 fresh count 200");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule